// File: doc/BRIEF.md
# Vertical Line Scaler and Field Splitter

This block takes a progressive pixel stream and shortens each frame to television height. A 480-line source becomes 400 lines, and a 600-line source becomes 576 lines. The block does not simply drop lines. Each output line is a weighted average of two neighbouring source lines, so detail that is one line high is spread over both interlaced fields and does not flicker. Output lines are tagged with a field bit. Even output lines go to field 0 and odd lines to field 1, so a downstream field writer can route them.

The input has a pixel valid, a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each line. A single buffer holds the previous source line. Output line k is produced while source line i+1 streams in, where i is the integer part of its phase. Each output pixel leaves one cycle after the input pixel that completes it. Three modes are selectable, and the settings are captured on the start-of-frame pixel:
- scaling with blending;
- line doubling, where pairs of identical output lines feed both fields;
- a bypass for test.

Top module: `vline_interlacer`

The line state machine chooses what each incoming line does. The choice is made on the line's last pixel, or forced on a start-of-frame pixel.
- **IDLE** holds after reset until the first frame start.
- **PRIME** loads source line 0.
- **SKIP** loads a line without output.
- **BLEND** emits a blended line.
- **REPLAY** re-emits the stored copy of the previous output line (doubling mode).
- **PASS** forwards every line unchanged (bypass).

The transitions are:
- frame start goes to PASS when bypass is selected, otherwise to PRIME;
- from PRIME, SKIP or REPLAY, go to BLEND when the phase's integer part equals the current line index and the output line cap is not yet reached; otherwise go to SKIP;
- from BLEND, go to REPLAY in doubling mode; otherwise take the same BLEND/SKIP test as above;
- IDLE and PASS stay in place until a frame start.

## Requirements
- R1: After reset, out_valid is low, and pixels that arrive before the first start-of-frame marker produce no output.
- R2: In scaling mode, output line k has phase P = k*STEP. STEP = floor(SRC*256/DST), with 480/400 when cfg_pal=0 and 600/576 when cfg_pal=1. With i = P>>8 and w = (P>>4)&15, pixel x = (L_i[x]*(16-w) + L_(i+1)[x]*w + 8) >> 4.
- R3: A full frame gives exactly 400 output lines (cfg_pal=0, 480 source lines) or 576 (cfg_pal=1, 600 source lines) in scaling and doubling modes.
- R4: Output line k is emitted while source line i+1 arrives. Each output pixel appears one cycle after its input pixel, and out_eol marks the last pixel of every output line.
- R5: out_field is bit 0 of the output line index. The index restarts at 0 on every frame start.
- R6: In doubling mode, output lines 2j and 2j+1 are identical and use phase j*2*STEP. Line 2j is emitted during source line i+1 and line 2j+1 during source line i+2.
- R7: In bypass, every source line is forwarded unchanged, and line n carries field n&1.
- R8: A frame start in the middle of a frame restarts the phase, the line count and the output index.
- R9: Mode inputs are captured only on the start-of-frame pixel. Changing them mid-frame has no effect on that frame.
- R10: out_valid is high only in the cycle after an accepted input pixel. Gaps in in_valid add no extra output beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pal | input | 1 | 0: 480 to 400 lines, 1: 600 to 576 lines |
| cfg_double | input | 1 | Line-doubling mode |
| cfg_bypass | input | 1 | Pass lines unscaled |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | PIX_W | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Output pixel |
| out_eol | output | 1 | Last pixel of an output line |
| out_field | output | 1 | Field tag of the output line |

## Verification
A wrong accumulator value shows at once as wrong pixel values, because the weight changes, or one line later as an output line appearing in the wrong source slot. A stale field counter flips out_field on the first output line after a frame start. A state machine that takes a wrong branch adds or loses whole output lines. The bench therefore compares every output beat against a behavioural expectation queue and checks the line count at the end of every frame.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRIME,
        S_SKIP,
        S_BLEND,
        S_REPLAY,
        S_PASS
    } line_state_e;

endpackage

// File: rtl/vls_linebuf.sv
module vls_linebuf #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Read returns the old content; a write in the same cycle lands after.
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

endmodule

// File: rtl/vls_blend.sv
module vls_blend #(
    parameter int PIX_W = 8,
    parameter int WGT   = 4
) (
    input  logic [PIX_W-1:0] upper,
    input  logic [PIX_W-1:0] lower,
    input  logic [WGT-1:0]   w,
    output logic [PIX_W-1:0] y
);

    localparam int SUM_W = PIX_W + WGT + 1;
    localparam logic [SUM_W-1:0] ONE  = SUM_W'(1) << WGT;
    localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (WGT - 1);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(upper) * (ONE - SUM_W'(w)) + SUM_W'(lower) * SUM_W'(w) + HALF;
        y   = sum[WGT +: PIX_W];
    end

    // R2: a weighted mean never leaves the range of its two inputs
    always_comb begin
        p_blend_range_r2: assert ((y >= upper && y <= lower) || (y >= lower && y <= upper));
    end

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int SRC_NTSC = 480,
    parameter int DST_NTSC = 400,
    parameter int SRC_PAL  = 600,
    parameter int DST_PAL  = 576,
    parameter int FRAC     = 8,
    parameter int WGT      = 4,
    parameter int XW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic          cfg_pal,
    input  logic          cfg_double,
    input  logic          cfg_bypass,
    output line_state_e   st,
    output logic [XW-1:0] px,
    output logic [WGT-1:0] wgt,
    output logic          field,
    output logic          dbl
);

    localparam int SRC_MAX = (SRC_NTSC > SRC_PAL) ? SRC_NTSC : SRC_PAL;
    localparam int ACC_W   = $clog2(SRC_MAX * (2 ** FRAC)) + 2;
    localparam int LN_W    = ACC_W - FRAC;
    localparam logic [ACC_W-1:0] STEP_N = ACC_W'(SRC_NTSC * (2 ** FRAC) / DST_NTSC);
    localparam logic [ACC_W-1:0] STEP_P = ACC_W'(SRC_PAL * (2 ** FRAC) / DST_PAL);
    localparam logic [LN_W-1:0]  CAP_N  = LN_W'(DST_NTSC);
    localparam logic [LN_W-1:0]  CAP_P  = LN_W'(DST_PAL);

    line_state_e      state_q, eff_state, nxt;
    logic [XW-1:0]    x_q, eff_x;
    logic [LN_W-1:0]  line_q, eff_line, idx_q, eff_idx, idx_after, cap;
    logic [ACC_W-1:0] acc_q, eff_acc, acc_after, adv;
    logic             pal_q, dbl_q, eff_pal, eff_dbl, emitting, hit;

    // a frame-start pixel overrides the stored line context
    always_comb begin
        if (in_sof) begin
            eff_state = cfg_bypass ? S_PASS : S_PRIME;
            eff_x     = '0;
            eff_line  = '0;
            eff_idx   = '0;
            eff_acc   = '0;
            eff_pal   = cfg_pal;
            eff_dbl   = cfg_double;
        end else begin
            eff_state = state_q;
            eff_x     = x_q;
            eff_line  = line_q;
            eff_idx   = idx_q;
            eff_acc   = acc_q;
            eff_pal   = pal_q;
            eff_dbl   = dbl_q;
        end
    end

    // next-line decision and outputs
    always_comb begin
        emitting  = (eff_state == S_BLEND) || (eff_state == S_REPLAY) || (eff_state == S_PASS);
        adv       = eff_pal ? STEP_P : STEP_N;
        if (eff_dbl) adv = adv << 1;
        acc_after = eff_acc + ((eff_state == S_BLEND) ? adv : '0);
        idx_after = eff_idx + LN_W'(emitting);
        cap       = eff_pal ? CAP_P : CAP_N;
        hit       = (acc_after[ACC_W-1:FRAC] == eff_line) && (idx_after < cap);
        unique case (eff_state)
            S_IDLE:   nxt = S_IDLE;
            S_PASS:   nxt = S_PASS;
            S_BLEND:  nxt = eff_dbl ? S_REPLAY : (hit ? S_BLEND : S_SKIP);
            S_PRIME,
            S_SKIP,
            S_REPLAY: nxt = hit ? S_BLEND : S_SKIP;
            default:  nxt = S_IDLE;
        endcase
        st    = eff_state;
        px    = eff_x;
        wgt   = eff_acc[FRAC-1 -: WGT];
        field = eff_idx[0];
        dbl   = eff_dbl;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            x_q     <= '0;
            line_q  <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            pal_q   <= 1'b0;
            dbl_q   <= 1'b0;
        end else if (in_valid) begin
            pal_q <= eff_pal;
            dbl_q <= eff_dbl;
            if (in_eol) begin
                state_q <= nxt;
                x_q     <= '0;
                line_q  <= eff_line + 1'b1;
                idx_q   <= idx_after;
                acc_q   <= acc_after;
            end else begin
                state_q <= eff_state;
                x_q     <= eff_x + 1'b1;
                line_q  <= eff_line;
                idx_q   <= eff_idx;
                acc_q   <= eff_acc;
            end
        end
    end

    // R6: a replayed line exists only in doubling mode
    p_replay_dbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REPLAY) |-> dbl_q);

    // R8: the phase only moves backwards on a frame start
    p_acc_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof) |=> (acc_q >= $past(acc_q)));

    // R3: the output line index never passes the target height while scaling
    p_line_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PASS) |-> (idx_q <= (pal_q ? CAP_P : CAP_N)));

endmodule

// File: rtl/vline_interlacer.sv
module vline_interlacer
    import vls_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int LINE_W     = 64,
    parameter int SRC_NTSC   = 480,
    parameter int DST_NTSC   = 400,
    parameter int SRC_PAL    = 600,
    parameter int DST_PAL    = 576,
    parameter int WGT        = 4,
    parameter bit HAS_DOUBLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pal,
    input  logic             cfg_double,
    input  logic             cfg_bypass,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_eol,
    output logic             out_field
);

    localparam int XW   = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int FRAC = 8;

    line_state_e      st;
    logic [XW-1:0]    px;
    logic [WGT-1:0]   wgt;
    logic             field, dbl, emit;
    logic [PIX_W-1:0] prev_pix, blend_pix, hold_pix, sel_pix;

    vls_ctrl #(
        .SRC_NTSC (SRC_NTSC), .DST_NTSC (DST_NTSC),
        .SRC_PAL  (SRC_PAL),  .DST_PAL  (DST_PAL),
        .FRAC     (FRAC),     .WGT      (WGT),
        .XW       (XW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .cfg_pal    (cfg_pal),
        .cfg_double (cfg_double),
        .cfg_bypass (cfg_bypass),
        .st         (st),
        .px         (px),
        .wgt        (wgt),
        .field      (field),
        .dbl        (dbl)
    );

    vls_linebuf #(.W(PIX_W), .DEPTH(LINE_W), .AW(XW)) u_prev (
        .clk   (clk),
        .we    (in_valid && st != S_IDLE),
        .addr  (px),
        .wdata (in_pix),
        .rdata (prev_pix)
    );

    vls_blend #(.PIX_W(PIX_W), .WGT(WGT)) u_blend (
        .upper (prev_pix),
        .lower (in_pix),
        .w     (wgt),
        .y     (blend_pix)
    );

    generate
        if (HAS_DOUBLE) begin : g_hold
            vls_linebuf #(.W(PIX_W), .DEPTH(LINE_W), .AW(XW)) u_hold (
                .clk   (clk),
                .we    (in_valid && st == S_BLEND && dbl),
                .addr  (px),
                .wdata (blend_pix),
                .rdata (hold_pix)
            );
        end else begin : g_no_hold
            assign hold_pix = '0;
        end
    endgenerate

    always_comb begin
        unique case (st)
            S_BLEND:  sel_pix = blend_pix;
            S_REPLAY: sel_pix = hold_pix;
            S_PASS:   sel_pix = in_pix;
            default:  sel_pix = '0;
        endcase
        emit = in_valid && (st == S_BLEND || st == S_REPLAY || st == S_PASS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_eol   <= 1'b0;
            out_field <= 1'b0;
        end else begin
            out_valid <= emit;
            out_pix   <= sel_pix;
            out_eol   <= emit && in_eol;
            out_field <= field;
        end
    end

    // R10: every output beat is backed by an accepted input pixel
    p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R7: in bypass the pixel leaves untouched one cycle later
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(st) == S_PASS) |-> (out_pix == $past(in_pix)));

endmodule

// File: tb/vline_interlacer_test.sv
`timescale 1ns/1ps
module vline_interlacer_test;

    localparam int LW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pal = 1'b0, cfg_double = 1'b0, cfg_bypass = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [7:0] in_pix = '0;
    logic       out_valid, out_eol, out_field;
    logic [7:0] out_pix;

    int    checks = 0, fails = 0;
    int    exp_q[$];
    int    exp_lines = 0, got_lines = 0;
    logic  last_iv = 1'b0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    vline_interlacer #(.LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pal(cfg_pal), .cfg_double(cfg_double), .cfg_bypass(cfg_bypass),
        .in_valid(in_valid), .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_pix(out_pix), .out_eol(out_eol), .out_field(out_field)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int srcpix(int l, int x, int seed);
        return (l * 29 + x * 71 + l * x * 3 + seed) & 255;
    endfunction

    // expected beats of one frame, from the requirement formulas
    task automatic plan(int nl, bit pal, bit dbl, bit byp, int seed);
        int dst, step;
        exp_lines = 0;
        if (byp) begin
            for (int l = 0; l < nl; l++) begin
                for (int x = 0; x < LW; x++)
                    exp_q.push_back(srcpix(l, x, seed) | ((l & 1) << 8) | ((x == LW - 1) << 9));
                exp_lines++;
            end
            return;
        end
        dst  = pal ? 576 : 400;
        step = pal ? (600 * 256 / 576) : (480 * 256 / 400);
        for (int k = 0; k < dst; k++) begin
            int p, i, w, slot;
            p    = dbl ? (k / 2) * 2 * step : k * step;
            i    = p >> 8;
            w    = (p >> 4) & 15;
            slot = (dbl && (k % 2 == 1)) ? i + 2 : i + 1;
            if (slot > nl - 1) break;
            for (int x = 0; x < LW; x++) begin
                int v;
                v = (srcpix(i, x, seed) * (16 - w) + srcpix(i + 1, x, seed) * w + 8) >> 4;
                exp_q.push_back(v | ((k & 1) << 8) | ((x == LW - 1) << 9));
            end
            exp_lines++;
        end
    endtask

    task automatic put(bit v, int pix, bit sof, bit eol);
        @(posedge clk); #1;
        in_valid = v; in_pix = 8'(pix); in_sof = sof; in_eol = eol;
    endtask

    task automatic send(int nl, bit pal, bit dbl, bit byp, int seed, bit gap, bit flip);
        cfg_pal = pal; cfg_double = dbl; cfg_bypass = byp;
        for (int l = 0; l < nl; l++) begin
            for (int x = 0; x < LW; x++) begin
                if (flip && l == 100 && x == 1) begin
                    cfg_pal = ~pal; cfg_bypass = 1'b1; cfg_double = ~dbl;
                end
                put(1'b1, srcpix(l, x, seed), (l == 0 && x == 0), (x == LW - 1));
                if (gap) put(1'b0, 0, 1'b0, 1'b0);
            end
        end
    endtask

    task automatic drain(string req);
        repeat (3) put(1'b0, 0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(got_lines == exp_lines, req, got_lines, exp_lines);
        exp_q.delete();
        got_lines = 0;
    endtask

    always @(posedge clk) last_iv <= in_valid;

    // compare every output beat against the expectation queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            chk(last_iv == 1'b1, "R10", int'(last_iv), 1);
            if (out_eol) got_lines++;
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_req, " unexpected beat"}, int'(out_pix), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(out_pix) == (e & 255), cur_req, int'(out_pix), e & 255);
                chk(out_field == e[8], "R5", int'(out_field), e[8]);
                chk(out_eol == e[9], "R4", int'(out_eol), e[9]);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
        rst_n = 1'b1;
        // R1: pixels before the first frame start are dropped
        cur_req = "R1";
        exp_lines = 0;
        for (int n = 0; n < 8; n++) put(1'b1, n * 13, 1'b0, (n % LW) == LW - 1);
        drain("R1");

        // R2, R3, R9: scaling 480 to 400 with mode inputs flipped mid-frame
        cur_req = "R2 R9";
        plan(480, 1'b0, 1'b0, 1'b0, 5);
        send(480, 1'b0, 1'b0, 1'b0, 5, 1'b0, 1'b1);
        drain("R3 ntsc");

        // R2, R3, R10: scaling 600 to 576 with gaps in the input
        cur_req = "R2 R10";
        plan(600, 1'b1, 1'b0, 1'b0, 77);
        send(600, 1'b1, 1'b0, 1'b0, 77, 1'b1, 1'b0);
        drain("R3 pal");

        // R8: frame cut short after 50 lines, then a fresh frame start
        cur_req = "R8";
        plan(50, 1'b0, 1'b0, 1'b0, 140);
        send(50, 1'b0, 1'b0, 1'b0, 140, 1'b0, 1'b0);
        drain("R8 cut");

        // R6: line doubling for both heights
        cur_req = "R6";
        plan(480, 1'b0, 1'b1, 1'b0, 33);
        send(480, 1'b0, 1'b1, 1'b0, 33, 1'b0, 1'b0);
        drain("R6 R3 ntsc");
        plan(600, 1'b1, 1'b1, 1'b0, 201);
        send(600, 1'b1, 1'b1, 1'b0, 201, 1'b0, 1'b0);
        drain("R6 R3 pal");

        // R7: bypass forwards every line
        cur_req = "R7";
        plan(20, 1'b1, 1'b1, 1'b1, 9);
        send(20, 1'b1, 1'b1, 1'b1, 9, 1'b0, 1'b0);
        drain("R7");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule